// File: doc/BRIEF.md
# Single-Cycle Integer Core with Fault Halt

This block is a small processor that completes one instruction per clock. Each cycle it fetches a word from an internal word-addressed memory. It then decodes the word, reads two source registers and runs the ALU. A load or store uses the same memory. The result is written to the register file and the program counter advances. The instruction set is a fixed set of nine opcodes: register arithmetic, immediate arithmetic and compares, load upper, word load and store, branch-on-equal and an absolute jump.

Memory has no reset. The environment fills it through a load port while the core is held in reset. When the core leaves reset it starts at address 0. Each architectural effect appears on two trace outputs while it commits: a register-write trace and a store trace.

The core checks every instruction for faults before it commits. A faulting instruction has no effect. The core then stops for good and raises `halted`. It stays stopped until the next reset.

Top module: `sc_core`

## Requirements
- R1: While reset is asserted and after it is released, `pc` reads 0 and `halted` reads 0; `wb_en` and `st_en` stay low while in reset.
- R2: The instruction word is split into fields as follows: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], funct [5:0], immediate [15:0] and jump index [25:0]. Any instruction that does not branch or jump moves `pc` to `pc`+4.
- R3: Opcode 0 writes rd with a result chosen by funct. The funct codes are 32 add, 34 subtract, 42 signed less-than (1/0), 43 unsigned less-than, 36 and, 37 or, 6 rt shifted left by 16 and 39 bitwise not of rs.
- R4: The immediate forms write rt. Opcode 8 adds, opcode 10 is a signed less-than and opcode 11 is an unsigned less-than. Each uses rs and the immediate, sign-extended by copying bit 15 into bits 31:16.
- R5: Opcode 15 writes rt with the immediate placed in bits 31:16 and zeros below.
- R6: The data address is rs plus the sign-extended immediate. Opcode 43 stores rt to that address and writes no register. Opcode 35 writes rt with the word at that address.
- R7: Opcode 4 subtracts rt from rs. When the result is zero, `pc` becomes `pc`+4 plus the sign-extended immediate shifted left by 2. Otherwise `pc` becomes `pc`+4. Opcode 4 never writes a register.
- R8: Opcode 2 sets `pc` to {bits 31:28 of `pc`+4, jump index, 2'b00}.
- R9: Register 0 always reads as zero. A write to register 0 is dropped and shows no register-write trace.
- R10: The core halts on any of these: an opcode outside the nine, an opcode-0 instruction with an unknown funct, or an opcode-0 instruction with a nonzero shift amount.
- R11: A load or store halts the core if its address is not a multiple of 4 or is above 4·MEM_WORDS−1.
- R12: Fetch halts the core if `pc` is not a multiple of 4 or is above 4·MEM_WORDS−1.
- R13: The faulting instruction writes nothing and leaves `pc` at its own address. After that, `halted` stays 1, and `pc`, registers and memory do not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| load_we | input | 1 | Write enable of the memory preload port |
| load_addr | input | IDX_W | Word index of the preload write |
| load_data | input | 32 | Word to preload |
| halted | output | 1 | Core stopped after a fault |
| pc | output | 32 | Current program counter |
| wb_en | output | 1 | A register write commits this cycle |
| wb_reg | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | A store commits this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Stored word |

## Verification
The assertions assume the preload port is used only while reset is held. Memory contents are therefore stable whenever the core is running. They also assume that registers an instruction reads were written earlier in the same run, so no compare ever sees an undefined value. The stimulus follows both rules. Every program is loaded during reset. Every program writes its source registers before reading them, apart from register 0. Each program ends in a deliberate fault, and the bench then checks that the core stays frozen.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JMP   = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_SLTIU = 6'd11;
  localparam logic [5:0] OPC_LUI   = 6'd15;
  localparam logic [5:0] OPC_LW    = 6'd35;
  localparam logic [5:0] OPC_SW    = 6'd43;

  localparam logic [5:0] FN_SHL16 = 6'd6;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;
  localparam logic [5:0] FN_AND   = 6'd36;
  localparam logic [5:0] FN_OR    = 6'd37;
  localparam logic [5:0] FN_NOT   = 6'd39;
  localparam logic [5:0] FN_SLT   = 6'd42;
  localparam logic [5:0] FN_SLTU  = 6'd43;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU,
    ALU_AND, ALU_OR, ALU_SHL16, ALU_NOT
  } alu_op_e;

  typedef struct packed {
    logic    legal;
    logic    wr_reg;
    logic    dst_rd;
    logic    use_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    alu_op_e alu;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl     = '0;
    ctrl.alu = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        ctrl.legal  = (shamt == 5'd0);
        ctrl.wr_reg = 1'b1;
        ctrl.dst_rd = 1'b1;
        case (funct)
          FN_ADD:   ctrl.alu = ALU_ADD;
          FN_SUB:   ctrl.alu = ALU_SUB;
          FN_SLT:   ctrl.alu = ALU_SLT;
          FN_SLTU:  ctrl.alu = ALU_SLTU;
          FN_AND:   ctrl.alu = ALU_AND;
          FN_OR:    ctrl.alu = ALU_OR;
          FN_SHL16: ctrl.alu = ALU_SHL16;
          FN_NOT:   ctrl.alu = ALU_NOT;
          default:  ctrl.legal = 1'b0;
        endcase
      end
      OPC_ADDI, OPC_SLTI, OPC_SLTIU, OPC_LUI: begin
        ctrl.legal   = 1'b1;
        ctrl.wr_reg  = 1'b1;
        ctrl.use_imm = 1'b1;
        case (opcode)
          OPC_SLTI:  ctrl.alu = ALU_SLT;
          OPC_SLTIU: ctrl.alu = ALU_SLTU;
          OPC_LUI:   ctrl.alu = ALU_SHL16;
          default:   ctrl.alu = ALU_ADD;
        endcase
      end
      OPC_LW: begin
        ctrl.legal   = 1'b1;
        ctrl.wr_reg  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OPC_SW: begin
        ctrl.legal   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.legal  = 1'b1;
        ctrl.branch = 1'b1;
        ctrl.alu    = ALU_SUB;
      end
      OPC_JMP: begin
        ctrl.legal = 1'b1;
        ctrl.jump  = 1'b1;
      end
      default: ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  localparam int HALF = W / 2;

  always_comb begin
    case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_SLT:   y = W'($signed(a) < $signed(b));
      ALU_SLTU:  y = W'(a < b);
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_SHL16: y = {b[HALF-1:0], {HALF{1'b0}}};
      default:   y = ~a;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);

  logic [W-1:0] regs [1:DEPTH-1];

  for (genvar g = 1; g < DEPTH; g++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (hit) regs[g] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr != '0)); // R9

endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W      = 32,
  parameter int WORDS  = 4096,
  localparam int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          ld_we,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_data,
  input  logic          st_we,
  input  logic [IW-1:0] st_idx,
  input  logic [W-1:0]  st_data,
  input  logic [IW-1:0] if_idx,
  output logic [W-1:0]  if_data,
  input  logic [IW-1:0] dt_idx,
  output logic [W-1:0]  dt_data
);

  logic [W-1:0] words [WORDS];
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;

  always_comb begin
    wr_en   = ld_we | st_we;
    wr_idx  = ld_we ? ld_idx  : st_idx;
    wr_data = ld_we ? ld_data : st_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  assign if_data = words[if_idx];
  assign dt_data = words[dt_idx];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int  MEM_WORDS = 4096,
  localparam int IDX_W     = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [IDX_W-1:0] load_addr,
  input  logic [31:0]      load_data,
  output logic             halted,
  output logic [31:0]      pc,
  output logic             wb_en,
  output logic [4:0]       wb_reg,
  output logic [31:0]      wb_data,
  output logic             st_en,
  output logic [31:0]      st_addr,
  output logic [31:0]      st_data
);

  localparam logic [XLEN-1:0] ADDR_LIMIT = XLEN'(MEM_WORDS * 4 - 1);
  localparam int              IMM_W      = 16;
  localparam int              JIDX_W     = 26;

  // reset: asserted at once, released on the clock
  logic rs_meta, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_q    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_q    <= rs_meta;
    end
  end

  logic [XLEN-1:0] pc_q, pc_d;
  logic            halt_q;
  logic            pc_en, halt_set;

  logic [XLEN-1:0] instr, dt_word;
  logic [5:0]      f_op, f_fn;
  logic [4:0]      f_rs, f_rt, f_rd, f_sh;
  logic [IMM_W-1:0]  f_imm;
  logic [JIDX_W-1:0] f_jidx;
  ctrl_t           ctrl;
  logic [XLEN-1:0] sext, src_a, src_b, alu_b, alu_y;
  logic            alu_zero;
  logic            fetch_bad, data_bad, mem_req, fault, commit;
  logic [XLEN-1:0] pc_inc, br_tgt, j_tgt, wb_val;
  logic [4:0]      dst;
  logic            rf_we, st_we;

  // field split
  always_comb begin
    f_op   = instr[31:26];
    f_rs   = instr[25:21];
    f_rt   = instr[20:16];
    f_rd   = instr[15:11];
    f_sh   = instr[10:6];
    f_fn   = instr[5:0];
    f_imm  = instr[15:0];
    f_jidx = instr[25:0];
    sext   = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  end

  sc_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .shamt  (f_sh),
    .ctrl   (ctrl)
  );

  sc_regfile #(.W(XLEN), .DEPTH(32)) u_rf (
    .clk   (clk),
    .rst_n (rs_q),
    .we    (rf_we),
    .waddr (dst),
    .wdata (wb_val),
    .ra1   (f_rs),
    .ra2   (f_rt),
    .rd1   (src_a),
    .rd2   (src_b)
  );

  assign alu_b = ctrl.use_imm ? sext : src_b;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (src_a),
    .b    (alu_b),
    .op   (ctrl.alu),
    .y    (alu_y),
    .zero (alu_zero)
  );

  sc_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
    .clk     (clk),
    .ld_we   (load_we),
    .ld_idx  (load_addr),
    .ld_data (load_data),
    .st_we   (st_we),
    .st_idx  (alu_y[IDX_W+1:2]),
    .st_data (src_b),
    .if_idx  (pc_q[IDX_W+1:2]),
    .if_data (instr),
    .dt_idx  (alu_y[IDX_W+1:2]),
    .dt_data (dt_word)
  );

  // fault detection
  always_comb begin
    fetch_bad = (pc_q[1:0] != 2'b00) || (pc_q > ADDR_LIMIT);
    mem_req   = ctrl.mem_rd | ctrl.mem_wr;
    data_bad  = (ctrl.mem_rd & ctrl.mem_wr) |
                (mem_req & ((alu_y[1:0] != 2'b00) || (alu_y > ADDR_LIMIT)));
    fault     = fetch_bad | ~ctrl.legal | data_bad;
    commit    = rs_q & ~halt_q & ~fault;
  end

  // writeback and store
  always_comb begin
    dst    = ctrl.dst_rd ? f_rd : f_rt;
    wb_val = ctrl.mem_rd ? dt_word : alu_y;
    rf_we  = commit & ctrl.wr_reg & (dst != 5'd0);
    st_we  = commit & ctrl.mem_wr;
  end

  // next state
  always_comb begin
    pc_inc   = pc_q + XLEN'(4);
    br_tgt   = pc_inc + {sext[XLEN-3:0], 2'b00};
    j_tgt    = {pc_inc[XLEN-1:XLEN-4], f_jidx, 2'b00};
    pc_en    = commit;
    halt_set = rs_q & ~halt_q & fault;
    if (ctrl.jump)                   pc_d = j_tgt;
    else if (ctrl.branch && alu_zero) pc_d = br_tgt;
    else                             pc_d = pc_inc;
  end

  // state registers
  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else begin
      if (pc_en)    pc_q   <= pc_d;
      if (halt_set) halt_q <= 1'b1;
    end
  end

  assign halted  = halt_q;
  assign pc      = pc_q;
  assign wb_en   = rf_we;
  assign wb_reg  = dst;
  assign wb_data = wb_val;
  assign st_en   = st_we;
  assign st_addr = alu_y;
  assign st_data = src_b;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rs_q)
    halt_q |=> halt_q); // R13
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rs_q)
    halt_q |=> $stable(pc_q)); // R13
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rs_q)
    (!halt_q && fault) |=> (halt_q && $stable(pc_q))); // R10
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rs_q)
    (commit && !ctrl.branch && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
  AST_BR_FALL: assert property (@(posedge clk) disable iff (!rs_q)
    (commit && ctrl.branch && !alu_zero) |=> (pc_q == $past(pc_q) + 32'd4)); // R7
  AST_BR_NO_WB: assert property (@(posedge clk) disable iff (!rs_q)
    ctrl.branch |-> !rf_we); // R7
  AST_ST_RANGE: assert property (@(posedge clk) disable iff (!rs_q)
    st_we |-> ((alu_y[1:0] == 2'b00) && (alu_y <= ADDR_LIMIT))); // R11
  AST_PC_RANGE: assert property (@(posedge clk) disable iff (!rs_q)
    commit |-> ((pc_q[1:0] == 2'b00) && (pc_q <= ADDR_LIMIT))); // R12

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int IDX_W      = $clog2(MEM_WORDS);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             load_we;
  logic [IDX_W-1:0] load_addr;
  logic [31:0]      load_data;
  logic             halted, wb_en, st_en;
  logic [31:0]      pc, wb_data, st_addr, st_data;
  logic [4:0]       wb_reg;

  int compared   = 0;
  int mismatched = 0;

  typedef struct {
    bit          is_st;
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } item_t;
  item_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core #(.MEM_WORDS(MEM_WORDS)) uut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .halted(halted), .pc(pc), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr),
    .st_data(st_data)
  );

  function automatic void check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'd2, 26'(idx)};
  endfunction

  task automatic exp_wb(int r, logic [31:0] d, string tag);
    expq.push_back('{1'b0, 32'(r), d, tag});
  endtask
  task automatic exp_st(logic [31:0] a, logic [31:0] d, string tag);
    expq.push_back('{1'b1, a, d, tag});
  endtask

  // monitor / scoreboard
  task automatic take(bit is_st, logic [31:0] a, logic [31:0] d);
    item_t e;
    if (expq.size() == 0) begin
      check("R13 unexpected event", {1'b1, a[30:0], d}, 64'd0);
    end else begin
      e = expq.pop_front();
      check(e.tag, {is_st, a[30:0], d}, {e.is_st, e.a[30:0], e.d});
    end
  endtask

  always @(negedge clk) begin
    if (wb_en) take(1'b0, {27'd0, wb_reg}, wb_data);
    if (st_en) take(1'b1, st_addr, st_data);
  end

  task automatic load(int idx, logic [31:0] w);
    @(negedge clk);
    load_we   = 1'b1;
    load_addr = IDX_W'(idx);
    load_data = w;
    @(negedge clk);
    load_we   = 1'b0;
  endtask

  task automatic enter_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 pc in reset", {32'd0, pc}, 64'd0);
    check("R1 halted/wb/st in reset", {61'd0, halted, wb_en, st_en}, 64'd0);
  endtask

  task automatic run_to_halt(logic [31:0] exp_pc, string tag);
    rst_n = 1'b1;
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
    check({tag, " halted"}, {63'd0, halted}, 64'd1);
    check({tag, " pc at fault"}, {32'd0, pc}, {32'd0, exp_pc});
    repeat (5) @(negedge clk);
    check("R13 frozen", {31'd0, halted, pc}, {31'd0, 1'b1, exp_pc});
    check("R13 queue drained", 64'(expq.size()), 64'd0);
    expq.delete();
  endtask

  initial begin
    rst_n = 1'b0; load_we = 1'b0; load_addr = '0; load_data = '0;
    repeat (3) @(negedge clk);

    // program 1: full instruction mix
    enter_reset();
    load(0,  enc_i(8, 0, 1, 5));          exp_wb(1, 32'd5, "R4 addi");
    load(1,  enc_i(8, 0, 2, -3));         exp_wb(2, 32'hFFFF_FFFD, "R4 addi sign extension");
    load(2,  enc_r(1, 2, 3, 32));         exp_wb(3, 32'd2, "R3 add");
    load(3,  enc_r(1, 2, 4, 34));         exp_wb(4, 32'd8, "R3 sub");
    load(4,  enc_r(2, 1, 5, 42));         exp_wb(5, 32'd1, "R3 slt signed");
    load(5,  enc_r(2, 1, 6, 43));         exp_wb(6, 32'd0, "R3 sltu");
    load(6,  enc_r(1, 2, 7, 36));         exp_wb(7, 32'd5, "R3 and");
    load(7,  enc_r(1, 2, 8, 37));         exp_wb(8, 32'hFFFF_FFFD, "R3 or");
    load(8,  enc_r(0, 1, 9, 6));          exp_wb(9, 32'h0005_0000, "R3 shift16");
    load(9,  enc_r(1, 0, 10, 39));        exp_wb(10, 32'hFFFF_FFFA, "R3 not");
    load(10, enc_i(10, 2, 11, -2));       exp_wb(11, 32'd1, "R4 slti");
    load(11, enc_i(11, 1, 12, -1));       exp_wb(12, 32'd1, "R4 sltiu");
    load(12, enc_i(15, 0, 13, 'h1234));   exp_wb(13, 32'h1234_0000, "R5 lui");
    load(13, enc_i(8, 0, 14, 'h100));     exp_wb(14, 32'h100, "R4 addi base");
    load(14, enc_i(43, 14, 1, 8));        exp_st(32'h108, 32'd5, "R6 sw");
    load(15, enc_i(35, 14, 15, 8));       exp_wb(15, 32'd5, "R6 lw");
    load(16, enc_i(8, 0, 0, 7));          // R9: write to r0 dropped
    load(17, enc_r(0, 1, 16, 32));        exp_wb(16, 32'd5, "R9 r0 reads zero");
    load(18, enc_i(4, 1, 2, 5));          // R7 not taken
    load(19, enc_i(4, 1, 15, 2));         // R7 taken to word 22
    load(20, enc_i(8, 0, 17, 1));
    load(21, enc_i(8, 0, 17, 2));
    load(22, enc_j(50));                  // R8 jump to 200
    load(23, enc_i(8, 0, 19, 3));
    load(50, enc_i(8, 0, 18, -1));        exp_wb(18, 32'hFFFF_FFFF, "R8 jump target");
    load(51, {6'd63, 26'd0});             // R10 unknown opcode
    run_to_halt(32'd204, "R10 opcode");

    // program 2: unknown funct
    enter_reset();
    load(0, enc_i(8, 0, 1, 1));           exp_wb(1, 32'd1, "R2 first instr");
    load(1, enc_r(1, 1, 2, 63));
    run_to_halt(32'd4, "R10 funct");

    // program 3: nonzero shift amount
    enter_reset();
    load(0, enc_i(8, 0, 1, 1));           exp_wb(1, 32'd1, "R2 first instr");
    load(1, enc_r(1, 1, 2, 32) | 32'h0000_0040);
    run_to_halt(32'd4, "R10 shamt");

    // program 4: misaligned load
    enter_reset();
    load(0, enc_i(8, 0, 1, 2));           exp_wb(1, 32'd2, "R2 first instr");
    load(1, enc_i(35, 1, 2, 0));
    run_to_halt(32'd4, "R11 misaligned");

    // program 5: store above the address limit
    enter_reset();
    load(0, enc_i(8, 0, 1, 'h4000));      exp_wb(1, 32'h4000, "R2 first instr");
    load(1, enc_i(43, 1, 1, 0));
    run_to_halt(32'd4, "R11 out of range");

    // program 6: jump outside fetch range
    enter_reset();
    load(0, enc_j('h1000));
    run_to_halt(32'h4000, "R12 fetch range");

    enter_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'd0, halted, 32'(pc != 32'hFFFF_FFFF)}, 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule